// File: doc/BRIEF.md
# Multi-Mode SPI Master Controller

This block is a register-programmed serial peripheral interface master. A small register bus sets the frame size, the clock polarity and phase, the transfer mode, the serial clock divider, the chip-select mask and a received-frame count. Words written to the data address go into an 8-deep transmit queue. Received frames land in an 8-deep receive queue, and reading the data address drains it. All traffic is MSB first, and a frame can be 4 to 16 bits long.

Four transfer modes are provided. Full-duplex exchanges one received frame for every transmitted one. Transmit-only throws the incoming bits away. Receive-only is started by a single dummy word and then clocks in a programmed number of frames. The memory-read mode first shifts out every queued command word, such as an opcode and address bytes. With no gap after them, it then clocks in a programmed number of frames. A transfer keeps the chip select low from its first frame to its last, as long as the queue keeps feeding it.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, every chip select is high and SCLK is low. The status word reads 0x0006 (transmit queue not full and empty). The control and divider registers read 0.
- R2: Control bits [3:0] hold the frame length minus one, with legal values 3 to 15. Frames are shifted MSB first, and a received frame is returned right-aligned with its upper bits cleared.
- R3: Control bit 7 sets the level SCLK rests at. With control bit 6 clear, data is sampled on the leading edge of each bit and driven on the trailing edge. With bit 6 set, data is driven on the leading edge and sampled on the trailing edge.
- R4: For an even divider value D (2 to 0xFFFE), SCLK has a period of D system clocks. A divider of 0 means no transfer ever starts.
- R5: Setting bit n of the select register (address 3) means only chip select n goes low. It falls once per transfer, stays low across back-to-back frames, and rises D/2 clocks after the final SCLK edge.
- R6: Control bits [9:8] = 0 select full-duplex mode. Each queued word is sent, and the frame received at the same time is queued for reading.
- R7: Mode 1 is transmit-only. Every queued word is sent, and nothing is added to the receive queue.
- R8: Mode 2 is receive-only. Writing one dummy word starts the transfer. The block then clocks in N+1 frames while holding MOSI low, where N is the frame-count register at address 1.
- R9: Mode 3 is memory-read. The block sends all queued command words, then clocks in N+1 frames with MOSI low and no break in the chip select. Only those N+1 frames are queued for reading.
- R10: The enable register is at address 4. While it is 1, writes to control (address 0), divider (address 2) and select (address 3) are ignored. Writing 0 to it stops any transfer at once and empties both queues.
- R11: The status register is at address 5. Bit 0 is busy, set while a serial transfer is in progress. Bit 1 is transmit-not-full, bit 2 is transmit-empty and bit 3 is receive-not-empty. Address 6 is the data register: a write queues a word and a read removes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 6) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 16 | Active-low chip selects |

## Verification
On every cycle, the checker enforces several rules. Chip selects fall only during a transfer and only inside the select mask. SCLK rests at its polarity level whenever the block is idle. The configuration stays frozen while the block is enabled. Disabling the block or programming a zero divider keeps it from being busy, transmit-only mode never writes the receive queue, and the transmit queue never holds more than its depth. Only the bench scenarios, driving a behavioural slave, can show the rest: the exact bit order and phase of each frame, the length of the frame sequence in each mode, the SCLK period, and the chip-select release delay.

// File: rtl/spim_pkg.sv
// Shared types and register addresses for the SPI master controller.
// Assumes a 3-bit word-addressed register bus.
package spim_pkg;

    typedef enum logic [1:0] {
        MODE_DUPLEX = 2'd0,
        MODE_TXONLY = 2'd1,
        MODE_RXONLY = 2'd2,
        MODE_MEMRD  = 2'd3
    } spim_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } spim_state_e;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_COUNT  = 3'd1;
    localparam logic [2:0] ADR_BAUD   = 3'd2;
    localparam logic [2:0] ADR_SELECT = 3'd3;
    localparam logic [2:0] ADR_ENABLE = 3'd4;
    localparam logic [2:0] ADR_STATUS = 3'd5;
    localparam logic [2:0] ADR_DATA   = 3'd6;

endpackage

// File: rtl/spim_fifo.sv
// Show-ahead synchronous queue. The head word is visible on rdata while the
// queue is not empty. A push into a full queue and a pop from an empty one
// are dropped. Assumes DEPTH is a power of two. A flush empties it in one cycle.
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic [AW:0]  level
);
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign level = wp - rp;
    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));
    assign rdata = mem[rp[AW-1:0]];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= wdata;
    end

    // Pointer update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/spim_engine.sv
// Serial shift engine. It produces SCLK from a half-period counter, shifts
// frames MSB first in either phase, and sequences frames by transfer mode.
// Assumes the configuration inputs stay stable while enable is high, and that
// the transmit queue is show-ahead.
module spim_engine
    import spim_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int BW = 16,
    localparam int FW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  spim_mode_e    mode,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [FW-1:0] fsz_m1,
    input  logic [CW-1:0] ndf,
    input  logic [BW-1:0] baud,
    input  logic          miso,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          sclk,
    output logic          mosi,
    output logic          busy
);
    spim_state_e   state;
    logic [BW-2:0] hcnt;
    logic [BW-2:0] half;
    logic [FW+1:0] ecnt;
    logic [CW-1:0] fcnt;
    logic          tog, rx_phase, mosi_q;
    logic [DW-1:0] tx_sh, rx_sh, rx_next;
    logic [FW:0]   nbits;
    logic          tick, last_edge, lead, sample_ev, drive_ev, start, fend;
    logic          cont, from_tx, go_rx;
    logic [DW-1:0] al_start, al_next;

    assign half      = baud[BW-1:1];
    assign nbits     = {1'b0, fsz_m1} + 1'b1;
    assign tick      = (hcnt == '0);
    assign last_edge = (ecnt == ({nbits, 1'b0} - (FW+2)'(1)));
    assign lead      = ~ecnt[0];
    assign sample_ev = tick && (state == ST_SHIFT) && (lead != cpha);
    assign drive_ev  = tick && (state == ST_SHIFT) && (lead == cpha) && !last_edge;
    assign start     = (state == ST_IDLE) && enable && !tx_empty && (half != '0);
    assign fend      = tick && (state == ST_SHIFT) && last_edge;
    assign rx_next   = {rx_sh[DW-2:0], miso};

    // Left-align a word so that its MSB is the first bit shifted out.
    function automatic logic [DW-1:0] align(input logic [DW-1:0] w, input logic [FW:0] n);
        return w << ((FW+1)'(DW) - n);
    endfunction

    // Decide at a frame end whether and how the transfer continues.
    always_comb begin
        cont    = 1'b0;
        from_tx = 1'b0;
        go_rx   = 1'b0;
        case (mode)
            MODE_DUPLEX, MODE_TXONLY: begin
                cont    = !tx_empty;
                from_tx = !tx_empty;
            end
            MODE_RXONLY: cont = (fcnt != ndf);
            default: begin
                if (!rx_phase) begin
                    cont    = 1'b1;
                    from_tx = !tx_empty;
                    go_rx   = tx_empty;
                end else begin
                    cont = (fcnt != ndf);
                end
            end
        endcase
    end

    assign al_start = align((mode == MODE_RXONLY) ? '0 : tx_data, nbits);
    assign al_next  = align(from_tx ? tx_data : '0, nbits);
    assign tx_pop   = start || (fend && cont && from_tx);
    assign rx_push  = fend && ((mode == MODE_DUPLEX) || rx_phase);
    assign rx_data  = cpha ? rx_next : rx_sh;
    assign sclk     = cpol ^ tog;
    assign mosi     = mosi_q;
    assign busy     = (state != ST_IDLE);

    // Transfer sequencer: idle, edge-by-edge shifting, chip-select tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; hcnt <= '0; ecnt <= '0; fcnt <= '0;
            tog <= 1'b0; rx_phase <= 1'b0; mosi_q <= 1'b0;
            tx_sh <= '0; rx_sh <= '0;
        end else if (!enable) begin
            state <= ST_IDLE; hcnt <= '0; ecnt <= '0; tog <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_SHIFT;
                    hcnt     <= half - 1'b1;
                    ecnt     <= '0;
                    fcnt     <= '0;
                    tog      <= 1'b0;
                    rx_phase <= (mode == MODE_RXONLY);
                    rx_sh    <= '0;
                    tx_sh    <= cpha ? al_start : (al_start << 1);
                    if (!cpha) mosi_q <= al_start[DW-1];
                end
                ST_SHIFT: if (tick) begin
                    hcnt <= half - 1'b1;
                    tog  <= ~tog;
                    ecnt <= ecnt + 1'b1;
                    if (sample_ev) rx_sh <= rx_next;
                    if (drive_ev) begin
                        mosi_q <= tx_sh[DW-1];
                        tx_sh  <= tx_sh << 1;
                    end
                    if (last_edge) begin
                        ecnt <= '0;
                        if (rx_push) fcnt <= fcnt + 1'b1;
                        if (go_rx) begin
                            rx_phase <= 1'b1;
                            fcnt     <= '0;
                        end
                        if (cont) begin
                            rx_sh <= '0;
                            tx_sh <= cpha ? al_next : (al_next << 1);
                            if (!cpha) mosi_q <= al_next[DW-1];
                        end else begin
                            state <= ST_TAIL;
                        end
                    end
                end else begin
                    hcnt <= hcnt - 1'b1;
                end
                ST_TAIL: if (tick) state <= ST_IDLE;
                         else      hcnt  <= hcnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_master_ctrl.sv
// Top level of the SPI master. It holds the register file and the two queues,
// and decodes the chip selects around the shift engine. Assumes single-cycle
// bus strobes. Read data is combinational, and a read strobe at the data
// address pops the receive queue.
module spi_master_ctrl
    import spim_pkg::*;
#(
    parameter int NCS        = 16,
    parameter int DW         = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int CW         = 16,
    parameter int BW         = 16,
    localparam int FW        = $clog2(DW),
    localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [2:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    logic [9:0]     ctrl_q;
    logic [CW-1:0]  count_q;
    logic [BW-1:0]  baud_q;
    logic [NCS-1:0] sel_q;
    logic           en_q;
    logic           flush, busy;
    logic           tx_push, tx_pop, tx_empty, tx_full;
    logic           rx_push, rx_pop, rx_empty, rx_full;
    logic [DW-1:0]  tx_data, rx_wdata, rx_head;
    logic [LW-1:0]  tx_level, rx_level;
    logic           cfg_open;

    assign cfg_open = bus_wr && !en_q;
    assign flush    = bus_wr && (bus_addr == ADR_ENABLE) && !bus_wdata[0];
    assign tx_push  = bus_wr && (bus_addr == ADR_DATA);
    assign rx_pop   = bus_rd && (bus_addr == ADR_DATA);

    // Register file; configuration locks while the controller is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0; count_q <= '0; baud_q <= '0; sel_q <= '0; en_q <= 1'b0;
        end else begin
            if (cfg_open && bus_addr == ADR_CTRL)   ctrl_q <= bus_wdata[9:0];
            if (cfg_open && bus_addr == ADR_BAUD)   baud_q <= BW'(bus_wdata);
            if (cfg_open && bus_addr == ADR_SELECT) sel_q  <= NCS'(bus_wdata);
            if (bus_wr && bus_addr == ADR_COUNT)    count_q <= CW'(bus_wdata);
            if (bus_wr && bus_addr == ADR_ENABLE)   en_q   <= bus_wdata[0];
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (bus_addr)
            ADR_CTRL:   bus_rdata = DW'(ctrl_q);
            ADR_COUNT:  bus_rdata = DW'(count_q);
            ADR_BAUD:   bus_rdata = DW'(baud_q);
            ADR_SELECT: bus_rdata = DW'(sel_q);
            ADR_ENABLE: bus_rdata = DW'(en_q);
            ADR_STATUS: bus_rdata = DW'({!rx_empty, tx_empty, !tx_full, busy});
            ADR_DATA:   bus_rdata = rx_empty ? '0 : rx_head;
            default:    bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
        .rdata(tx_data), .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spim_engine #(.DW(DW), .CW(CW), .BW(BW)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(en_q),
        .mode(spim_mode_e'(ctrl_q[9:8])), .cpol(ctrl_q[7]), .cpha(ctrl_q[6]),
        .fsz_m1(ctrl_q[FW-1:0]), .ndf(count_q), .baud(baud_q), .miso(miso),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_wdata),
        .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    // One active-low select line per mask bit, held during a transfer.
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(sel_q[g] && busy);
    end
endmodule

// File: rtl/spim_checker.sv
// Protocol checker for spi_master_ctrl, attached to it by bind. It observes
// the select lines, the serial clock, the locked configuration and the
// queue activity.
module spim_checker #(
    parameter int NCS   = 16,
    parameter int BW    = 16,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           sclk,
    input logic [NCS-1:0] cs_n,
    input logic [NCS-1:0] sel_q,
    input logic [9:0]     ctrl_q,
    input logic [BW-1:0]  baud_q,
    input logic           en_q,
    input logic           rx_push,
    input logic [LW-1:0]  tx_level
);
    // R5
    cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> busy);
    // R5
    cs_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cs_n) & ~sel_q) == '0);
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ctrl_q[7]));
    // R10
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> ($stable(ctrl_q) && $stable(baud_q) && $stable(sel_q)));
    // R10
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !busy);
    // R4
    zero_baud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_q[BW-1:1] == '0 && !busy) |=> !busy);
    // R7
    txonly_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[9:8] == 2'd1) |-> !rx_push);
    // R11
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));
endmodule

bind spi_master_ctrl spim_checker #(.NCS(NCS), .BW(BW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .cs_n(cs_n),
    .sel_q(sel_q), .ctrl_q(ctrl_q), .baud_q(baud_q), .en_q(en_q),
    .rx_push(rx_push), .tx_level(tx_level)
);

// File: tb/tb_spi_master_ctrl.sv
// Bench: register-bus driver plus a behavioural SPI slave, directed corner
// cases, then seeded random scenarios checked against computed expectations.
module tb_spi_master_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, miso = 1'b0;
    logic [15:0] cs_n;

    int checks = 0, fails = 0;
    bit finished = 0;

    spi_master_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave model state
    int s_sel = 0, s_n = 8, s_cpol = 0, s_cpha = 0;
    int s_bit = 0, s_idx = 0, got_n = 0, cs_falls = 0, lead_cnt = 0;
    int cyc = 0, last_edge_cyc = 0, rel_gap = -1, bad_cs = 0;
    int lead_t [2];
    logic [15:0] s_in = '0;
    logic [15:0] slv_out [32];
    logic [15:0] got [32];
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        logic cs_now, ld, smp;
        cyc++;
        cs_now = cs_n[s_sel];
        if ((~cs_n & ~(16'd1 << s_sel)) != 16'd0) bad_cs++;
        if (prev_cs && !cs_now) begin
            cs_falls++;
            s_bit = 0;
            s_in = '0;
            if (s_cpha == 0) miso = slv_out[s_idx][s_n-1];
        end
        if (!cs_now && sclk != prev_sclk) begin
            last_edge_cyc = cyc;
            ld = (sclk != s_cpol[0]);
            if (ld) begin
                if (lead_cnt < 2) lead_t[lead_cnt] = cyc;
                lead_cnt++;
            end
            smp = s_cpha[0] ? !ld : ld;
            if (smp) begin
                s_in = (s_in << 1) | 16'(mosi);
                s_bit++;
                if (s_bit == s_n) begin
                    if (got_n < 32) got[got_n] = s_in;
                    got_n++;
                    s_in = '0;
                    s_bit = 0;
                    s_idx++;
                end
            end else begin
                miso = slv_out[s_idx][s_n-1-s_bit];
            end
        end
        if (!prev_cs && cs_now) rel_gap = cyc - last_edge_cyc;
        prev_cs = cs_now;
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = (a == 3'd6);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // One transfer: configure, preload, enable, wait, compare.
    task automatic run_xfer(input int mode, input int cpol, input int cpha, input int nb,
                            input int baud, input int sel, input int ndf, input int nw);
        logic [15:0] txw [16];
        logic [15:0] exp_s [32];
        logic [15:0] exp_r [32];
        logic [15:0] rx [16];
        logic [15:0] st, d, mask;
        int exp_sn, exp_rn, nrx, mism, fa, fe;
        string rq;
        rq = (mode == 0) ? "R6" : (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R9";
        mask = 16'((32'd1 << nb) - 1);
        bus_write(3'd4, 16'd0);
        s_sel = sel; s_n = nb; s_cpol = cpol; s_cpha = cpha;
        s_idx = 0; got_n = 0; cs_falls = 0; lead_cnt = 0; rel_gap = -1; bad_cs = 0;
        for (int i = 0; i < 32; i++) slv_out[i] = 16'($urandom) & mask;
        for (int i = 0; i < 16; i++) txw[i] = 16'($urandom) & mask;
        bus_write(3'd0, 16'((mode << 8) | (cpol << 7) | (cpha << 6) | (nb - 1)));
        bus_write(3'd2, 16'(baud));
        bus_write(3'd3, 16'(32'd1 << sel));
        bus_write(3'd1, 16'(ndf));
        if (mode == 2) bus_write(3'd6, 16'hA5A5);
        else for (int i = 0; i < nw; i++) bus_write(3'd6, txw[i]);
        bus_write(3'd4, 16'd1);
        bus_read(3'd5, st);
        check(st[0] == 1'b1, "R11", "busy after start", int'(st[0]), 1);
        for (int k = 0; k < 6000; k++) begin
            bus_read(3'd5, st);
            if (!st[0]) break;
        end
        repeat (2) @(negedge clk);
        exp_sn = 0; exp_rn = 0;
        case (mode)
            0: for (int i = 0; i < nw; i++) begin
                   exp_s[exp_sn++] = txw[i]; exp_r[exp_rn++] = slv_out[i];
               end
            1: for (int i = 0; i < nw; i++) exp_s[exp_sn++] = txw[i];
            2: for (int i = 0; i <= ndf; i++) begin
                   exp_s[exp_sn++] = '0; exp_r[exp_rn++] = slv_out[i];
               end
            default: begin
                for (int i = 0; i < nw; i++) exp_s[exp_sn++] = txw[i];
                for (int i = 0; i <= ndf; i++) begin
                    exp_s[exp_sn++] = '0; exp_r[exp_rn++] = slv_out[nw + i];
                end
            end
        endcase
        nrx = 0;
        for (int k = 0; k < 16; k++) begin
            bus_read(3'd5, st);
            if (!st[3]) break;
            bus_read(3'd6, d);
            rx[nrx++] = d;
        end
        check(got_n == exp_sn, rq, "slave frame count", got_n, exp_sn);
        mism = 0; fa = 0; fe = 0;
        for (int i = 0; i < exp_sn && i < got_n; i++)
            if (got[i] !== exp_s[i]) begin
                if (mism == 0) begin fa = int'(got[i]); fe = int'(exp_s[i]); end
                mism++;
            end
        check(mism == 0, "R2", "MOSI frame bits", fa, fe);
        check(nrx == exp_rn, rq, "received frame count", nrx, exp_rn);
        mism = 0; fa = 0; fe = 0;
        for (int i = 0; i < exp_rn && i < nrx; i++)
            if (rx[i] !== exp_r[i]) begin
                if (mism == 0) begin fa = int'(rx[i]); fe = int'(exp_r[i]); end
                mism++;
            end
        check(mism == 0, "R3", "MISO frame bits", fa, fe);
        check(cs_falls == 1, "R5", "select falls per transfer", cs_falls, 1);
        check(bad_cs == 0, "R5", "unselected line low", bad_cs, 0);
        check(rel_gap == baud / 2, "R5", "select release delay", rel_gap, baud / 2);
        check(lead_t[1] - lead_t[0] == baud, "R4", "SCLK period", lead_t[1] - lead_t[0], baud);
        check(sclk == cpol[0], "R3", "idle SCLK level", int'(sclk), cpol);
        bus_read(3'd5, st);
        check(st == 16'h0006, "R11", "status after drain", int'(st), 16'h0006);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, d;
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) slv_out[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd5, st);
        check(st == 16'h0006, "R1", "reset status", int'(st), 16'h0006);
        check(cs_n == 16'hFFFF, "R1", "reset selects", int'(cs_n), 16'hFFFF);
        check(sclk == 1'b0, "R1", "reset SCLK", int'(sclk), 0);
        bus_read(3'd0, d);
        check(d == 16'h0000, "R1", "reset control", int'(d), 0);
        bus_read(3'd2, d);
        check(d == 16'h0000, "R1", "reset divider", int'(d), 0);

        // R4 divider of zero: queued word never starts a transfer
        bus_write(3'd0, 16'h0007);
        bus_write(3'd3, 16'h0004);
        bus_write(3'd6, 16'h005A);
        bus_write(3'd4, 16'd1);
        repeat (60) @(negedge clk);
        bus_read(3'd5, st);
        check(st[0] == 1'b0 && st[2] == 1'b0, "R4", "zero divider status", int'(st), 16'h0002);
        check(cs_n == 16'hFFFF, "R4", "zero divider selects", int'(cs_n), 16'hFFFF);

        // R10 disable flushes the queue
        bus_write(3'd4, 16'd0);
        bus_read(3'd5, st);
        check(st == 16'h0006, "R10", "status after disable", int'(st), 16'h0006);

        // R10 configuration locked while enabled
        bus_write(3'd2, 16'd4);
        bus_write(3'd4, 16'd1);
        bus_write(3'd0, 16'h03C3);
        bus_write(3'd2, 16'd20);
        bus_write(3'd3, 16'h8000);
        bus_read(3'd0, d);
        check(d == 16'h0007, "R10", "control locked", int'(d), 16'h0007);
        bus_read(3'd2, d);
        check(d == 16'd4, "R10", "divider locked", int'(d), 4);
        bus_read(3'd3, d);
        check(d == 16'h0004, "R10", "select locked", int'(d), 16'h0004);
        bus_write(3'd4, 16'd0);

        // Directed corners
        run_xfer(0, 0, 0, 4, 2, 0, 0, 8);     // R6 full queue, shortest frame, fastest clock
        run_xfer(0, 1, 1, 16, 2, 15, 0, 3);   // R6 widest frame, top select line
        run_xfer(1, 0, 1, 8, 6, 3, 0, 5);     // R7
        run_xfer(2, 1, 0, 8, 4, 7, 0, 1);     // R8 single frame
        run_xfer(2, 0, 1, 12, 8, 2, 7, 1);    // R8 eight frames
        run_xfer(3, 0, 0, 8, 4, 1, 7, 4);     // R9 four commands then eight frames
        run_xfer(3, 1, 1, 5, 2, 9, 0, 1);     // R9 single command, single frame

        // Seeded random scenarios
        for (int r = 0; r < 16; r++) begin
            int m, nw, ndf;
            m   = int'($urandom_range(0, 3));
            nw  = int'($urandom_range(1, 8));
            ndf = int'($urandom_range(0, 7));
            run_xfer(m, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                     int'($urandom_range(4, 16)), 2 * int'($urandom_range(1, 6)),
                     int'($urandom_range(0, 15)), ndf, nw);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule